// File: doc/BRIEF.md
# OTG Protocol Timeout Timer

This block is a one-shot countdown used to time protocol phases of a dual-role USB port. Software programs it through one 32-bit register: the top bit arms the timer and the low 27 bits give the timeout length, counted in ticks of a 60 MHz device clock. The tick reaches the block as a one-cycle enable on the system clock. When the programmed number of ticks has passed, the block emits a one-cycle timeout pulse toward the interrupt controller, where it sets interrupt bit 16.

A write with the arm bit set starts a new timeout measured from that write, replacing any timeout already running. A write with the arm bit clear cancels the timeout. Software reads back the value it last wrote. The block does not return the live count. On expiry it zeroes the whole stored register, so a read of zero tells software that the timeout has fired. A separate internal down-counter holds the remaining ticks.

Top module: `otg_tmo_timer`

## Requirements
- R1: After reset `rd_data` is zero, no timeout is armed and `timeout_pulse` is low.
- R2: A write stores all 32 bits of `wr_data`, including bits 30:27, and `rd_data` shows them from the cycle after the write until the next write or expiry.
- R3: A write with bit 31 set and count N (bits 26:0, N at least 1) produces exactly one `timeout_pulse`. It is high in the cycle after the edge that samples the N-th `tick` following the write. A `tick` in the same cycle as the write is not counted.
- R4: A write with bit 31 set and count 0 expires on the first `tick` after the write, the same as count 1.
- R5: A write with bit 31 clear cancels a running timeout: no pulse follows until the next arming write.
- R6: A write with bit 31 set while a timeout runs restarts it with the new count, measured from the new write.
- R7: On expiry the stored register becomes zero in the same cycle that `timeout_pulse` is high, and the pulse lasts exactly one cycle.
- R8: Cycles without `tick` do not advance the countdown, and ticks while no timeout is armed have no effect on `rd_data` or `timeout_pulse`.
- R9: A write in the same cycle as the tick that would expire the timer takes priority. No pulse is produced and the stored value is the written one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: bit 31 arms the timer, bits 26:0 give the tick count |
| rd_data | output | 32 | Stored register value |
| tick | input | 1 | One-cycle enable at the device clock rate |
| timeout_pulse | output | 1 | One-cycle expiry pulse |

## Verification
The bench builds the block with its production widths: a 32-bit register, a 27-bit count field and the arm bit at 31. The random counts are kept below 32 so that many full expiries fit in a short run, with the upper bits 30:27 randomized to exercise full-width storage. The directed cases cover the zero count, cancel, restart, and a write that collides with the expiring tick. Counts near the 27-bit maximum are out of reach at these run lengths. The decrement logic is identical for every value, but those counts are never run to expiry.

// File: rtl/otg_tmo_pkg.sv
package otg_tmo_pkg;
   localparam int unsigned DEF_DATA_W = 32;
   localparam int unsigned DEF_CNT_W  = 27;
   localparam int unsigned DEF_EN_BIT = 31;

   typedef enum logic [1:0] {
      TMO_IDLE   = 2'd0,
      TMO_LOAD   = 2'd1,
      TMO_COUNT  = 2'd2,
      TMO_EXPIRE = 2'd3
   } tmo_evt_e;
endpackage

// File: rtl/otg_tmo_counter.sv
module otg_tmo_counter #(
   parameter int unsigned CNT_W = otg_tmo_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_arm,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             tick,
   output logic             expiring,
   output logic             pulse
);
   import otg_tmo_pkg::*;

   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic             armed;
   logic [CNT_W-1:0] remain;
   tmo_evt_e         evt;

   always_comb begin
      if (load)                                evt = TMO_LOAD;
      else if (tick && armed && remain <= LAST) evt = TMO_EXPIRE;
      else if (tick && armed)                  evt = TMO_COUNT;
      else                                     evt = TMO_IDLE;
   end

   assign expiring = (evt == TMO_EXPIRE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         remain <= '0;
         pulse  <= 1'b0;
      end else begin
         pulse <= 1'b0;
         case (evt)
            TMO_LOAD: begin
               armed  <= load_arm;
               remain <= load_cnt;
            end
            TMO_EXPIRE: begin
               armed <= 1'b0;
               pulse <= 1'b1;
            end
            TMO_COUNT: remain <= remain - 1'b1;
            default: ;
         endcase
      end
   end

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_arm) |=> (armed && remain == $past(load_cnt)));

   assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !load_arm) |=> (!armed && !pulse));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> ($stable(remain) && !pulse));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !pulse);

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/otg_tmo_reg.sv
module otg_tmo_reg #(
   parameter int unsigned DATA_W = otg_tmo_pkg::DEF_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clear,
   output logic [DATA_W-1:0] value
);
   always_ff @(posedge clk) begin
      if (!rst_n)       value <= '0;
      else if (wr_en)   value <= wr_data;
      else if (clear)   value <= '0;
   end

   assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (value == $past(wr_data)));

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !wr_en) |=> (value == '0));
endmodule

// File: rtl/otg_tmo_timer.sv
module otg_tmo_timer #(
   parameter int unsigned DATA_W = otg_tmo_pkg::DEF_DATA_W,
   parameter int unsigned CNT_W  = otg_tmo_pkg::DEF_CNT_W,
   parameter int unsigned EN_BIT = otg_tmo_pkg::DEF_EN_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tick,
   output logic              timeout_pulse
);
   generate
      if (CNT_W < 1 || CNT_W >= DATA_W) begin : g_bad_cnt
         $error("otg_tmo_timer: CNT_W must lie in 1..DATA_W-1");
      end
      if (EN_BIT < CNT_W || EN_BIT >= DATA_W) begin : g_bad_en
         $error("otg_tmo_timer: EN_BIT must lie above the count field");
      end
   endgenerate

   logic expiring;

   otg_tmo_reg #(.DATA_W(DATA_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .clear   (expiring),
      .value   (rd_data)
   );

   otg_tmo_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_en),
      .load_arm (wr_data[EN_BIT]),
      .load_cnt (wr_data[CNT_W-1:0]),
      .tick     (tick),
      .expiring (expiring),
      .pulse    (timeout_pulse)
   );

   assert_zero_on_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |-> (rd_data == '0));

   assert_reset_state_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (rd_data == '0 && !timeout_pulse));
endmodule

// File: tb/otg_tmo_timer_bench.sv
module otg_tmo_timer_bench;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned CNT_W  = 27;
   localparam int unsigned EN_BIT = 31;
   localparam logic [31:0] ARM = 32'h8000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rd_data;
   logic              tick = 1'b0;
   logic              timeout_pulse;

   int checks = 0;
   int fails  = 0;
   int pulses = 0;
   int cycles = 0;
   bit done   = 0;

   bit          m_armed;
   int          m_rem;
   logic [31:0] m_reg;
   bit          m_pulse;

   always #4 clk = ~clk;

   otg_tmo_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT)) u_otg_tmo_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .tick(tick), .timeout_pulse(timeout_pulse)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] arm_word(input int n);
      return ARM | (32'(n) & 32'h07FF_FFFF);
   endfunction

   task automatic step(input bit wr, input logic [31:0] d, input bit tk);
      bit expired;
      wr_en = wr; wr_data = d; tick = tk;
      @(posedge clk);
      expired = 0;
      m_pulse = 0;
      if (wr) begin
         m_reg = d; m_armed = d[EN_BIT]; m_rem = int'(d[CNT_W-1:0]);
      end else if (tk && m_armed) begin
         if (m_rem <= 1) begin
            m_armed = 0; m_pulse = 1; m_reg = '0; expired = 1;
         end else m_rem--;
      end
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
      if (timeout_pulse) pulses++;
      check(rd_data == m_reg, expired ? "R7" : "R2", rd_data, m_reg);
      check(timeout_pulse == m_pulse, "R3", 32'(timeout_pulse), 32'(m_pulse));
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      m_armed = 0; m_rem = 0; m_reg = '0; m_pulse = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(rd_data == '0, "R1", rd_data, 32'h0);
      check(timeout_pulse == 1'b0, "R1", 32'(timeout_pulse), 32'h0);

      // R2: full-width storage with arm clear
      step(1, 32'h7ABC_DEF1, 0);
      check(rd_data == 32'h7ABC_DEF1, "R2", rd_data, 32'h7ABC_DEF1);

      // R3: count 3, tick each cycle, tick in write cycle ignored
      pulses = 0;
      step(1, arm_word(3), 1);
      step(0, 0, 1); step(0, 0, 1);
      check(pulses == 0, "R3", 32'(pulses), 32'h0);
      step(0, 0, 1);
      check(timeout_pulse == 1'b1, "R3", 32'(timeout_pulse), 32'h1);
      check(rd_data == '0, "R7", rd_data, 32'h0);
      step(0, 0, 0);
      check(timeout_pulse == 1'b0, "R7", 32'(timeout_pulse), 32'h0);

      // R4: count zero expires on first tick
      step(1, arm_word(0), 0);
      step(0, 0, 1);
      check(timeout_pulse == 1'b1, "R4", 32'(timeout_pulse), 32'h1);

      // R5: cancel
      pulses = 0;
      step(1, arm_word(5), 0);
      step(0, 0, 1); step(0, 0, 1);
      step(1, 32'h0000_0005, 0);
      for (int i = 0; i < 10; i++) step(0, 0, 1);
      check(pulses == 0, "R5", 32'(pulses), 32'h0);
      check(rd_data == 32'h5, "R5", rd_data, 32'h5);

      // R6: restart with shorter count
      pulses = 0;
      step(1, arm_word(10), 0);
      for (int i = 0; i < 5; i++) step(0, 0, 1);
      step(1, arm_word(2), 0);
      step(0, 0, 1);
      check(pulses == 0, "R6", 32'(pulses), 32'h0);
      step(0, 0, 1);
      check(timeout_pulse == 1'b1, "R6", 32'(timeout_pulse), 32'h1);

      // R8: gaps without tick, and idle ticks
      pulses = 0;
      step(1, arm_word(2), 0);
      for (int i = 0; i < 5; i++) step(0, 0, 0);
      step(0, 0, 1);
      check(pulses == 0, "R8", 32'(pulses), 32'h0);
      step(0, 0, 1);
      check(pulses == 1, "R8", 32'(pulses), 32'h1);
      for (int i = 0; i < 4; i++) step(0, 0, 1);
      check(pulses == 1 && rd_data == '0, "R8", rd_data, 32'h0);

      // R9: write collides with expiring tick
      pulses = 0;
      step(1, arm_word(1), 0);
      step(1, arm_word(4), 1);
      check(timeout_pulse == 1'b0, "R9", 32'(timeout_pulse), 32'h0);
      check(rd_data == arm_word(4), "R9", rd_data, arm_word(4));
      for (int i = 0; i < 4; i++) step(0, 0, 1);
      check(pulses == 1, "R9", 32'(pulses), 32'h1);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         bit          wr;
         bit          tk;
         logic [31:0] d;
         wr = ($urandom % 20) == 0;
         tk = ($urandom % 2) == 0;
         d  = {($urandom % 10) < 7, 4'($urandom), 22'h0, 5'($urandom)};
         step(wr, d, tk);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule